// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Timer Registers

This block sits between an 8-bit data bus and the bank of 16-bit registers of a timer. It lets software move a full 16-bit value across the narrow bus so that both halves change, or are sampled, in the same clock cycle. One staging byte serves the whole bank for this. A low-byte write parks the byte in the staging register. A later high-byte write commits the high byte from the bus and the low byte from the staging register together. A low-byte read returns the live low byte and, in that same edge, copies the live high byte into the staging register. A later high-byte read returns that copy. This gives a consistent snapshot of a free-running counter.

The bank holds `N_WIDE` 16-bit registers. Register 0 is the running count, and it advances on every clock while `cnt_run` is high. The other registers are plain storage. Above them sit `N_NARROW` 8-bit registers, and these never use the staging byte. Every wide register shares the same staging byte. Software must therefore not interleave two 16-bit accesses. If it does, the second access overwrites the byte the first one left behind, and the result is a predictable corruption that the bench reproduces.

Top module: `tmr_byte_bridge`

## Requirements
- R1: A synchronous active-high reset clears every wide register, every narrow register and the staging byte to 0.
- R2: A write to the even (low) byte address 2k of wide register k loads the bus byte into the staging byte only, and register k keeps its value.
- R3: A write to the odd (high) byte address 2k+1 sets register k to {bus byte, staging byte} at a single clock edge. The staging byte is left unchanged.
- R4: A read of low byte address 2k returns bits 7:0 of register k in the same cycle. At that cycle's clock edge it also copies bits 15:8 of register k into the staging byte.
- R5: A read of high byte address 2k+1 returns the staging byte, not the live high byte.
- R6: While `cnt_run` is 1, register 0 increases by one per clock and wraps from 0xFFFF to 0x0000.
- R7: A high-byte write to register 0 takes priority over counting in that cycle. The written value appears exactly and counting resumes from it.
- R8: Reads and writes of the 8-bit registers at addresses 2*N_WIDE to 2*N_WIDE+N_NARROW-1 work directly and leave the staging byte unchanged.
- R9: The staging byte is shared. An intervening wide access between the two halves of another register's access changes the committed value. For example, low(reg1)=AA, then low(reg2)=55, then high(reg1)=11 gives reg1 = 0x1155.
- R10: When `bus_wr` and `bus_rd` are both 1, only the write is performed.
- R11: `bus_rdata` is 0 in any cycle without a read of a mapped address. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_run | input | 1 | Enables counting of register 0 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of the read |

## Verification
The bench loads the running counter just below a carry from the low byte into the high byte. It then reads the counter across that carry. A bridge that returned the live high byte would report 0x01FF instead of the snapshot 0x00FF. It interleaves accesses to different wide registers and expects the exact corrupted value. A design with a separate staging byte per register would hide that case. It also checks the cases below:
- The counter wrap. A wrong design would saturate or spill past 16 bits.
- A high-byte write while the counter runs. A wrong design would let counting override the write, giving +1.
- Narrow-register traffic between the two halves of a wide write. A design that clobbers the staging byte here would commit the wrong low byte.
- Simultaneous read and write strobes.
- Unmapped addresses.
- Reset in the middle of a two-byte write.

// File: rtl/tbb_pkg.sv
package tbb_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_WIDE_LO = 2'd1,
        ACC_WIDE_HI = 2'd2,
        ACC_NARROW  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      is_wr;
        logic      is_rd;
        byte_t     idx;
        byte_t     data;
    } bus_op_t;

    // Classify one bus cycle; a write always wins over a read.
    function automatic bus_op_t decode_op(input byte_t addr, input logic wr,
                                          input logic rd, input byte_t data,
                                          input int n_wide, input int n_narrow);
        bus_op_t op;
        int a;
        a        = int'(addr);
        op.is_wr = wr;
        op.is_rd = rd & ~wr;
        op.data  = data;
        op.idx   = '0;
        op.kind  = ACC_NONE;
        if (wr | rd) begin
            if (a < 2 * n_wide) begin
                op.kind = addr[0] ? ACC_WIDE_HI : ACC_WIDE_LO;
                op.idx  = byte_t'(a >> 1);
            end else if (a < 2 * n_wide + n_narrow) begin
                op.kind = ACC_NARROW;
                op.idx  = byte_t'(a - 2 * n_wide);
            end
        end
        return op;
    endfunction
endpackage

// File: rtl/tbb_decode.sv
module tbb_decode
    import tbb_pkg::*;
#(
    parameter int N_WIDE   = 4,
    parameter int N_NARROW = 2,
    parameter int ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  byte_t             bus_wdata,
    output bus_op_t           op
);
    byte_t addr_ext;

    always_comb begin
        addr_ext = '0;
        addr_ext[ADDR_W-1:0] = bus_addr;
        op = decode_op(addr_ext, bus_wr, bus_rd, bus_wdata, N_WIDE, N_NARROW);
    end
endmodule

// File: rtl/tbb_stage.sv
module tbb_stage
    import tbb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    input  byte_t   sel_hi,
    output byte_t   temp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else if (op.kind == ACC_WIDE_LO) begin
            if (op.is_wr)      temp_q <= op.data;
            else if (op.is_rd) temp_q <= sel_hi;
        end
    end
endmodule

// File: rtl/tbb_wide_bank.sv
module tbb_wide_bank
    import tbb_pkg::*;
#(
    parameter int N_WIDE  = 4,
    parameter int CNT_IDX = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnt_run,
    input  bus_op_t                 op,
    input  byte_t                   temp_q,
    output logic [N_WIDE-1:0][WORD_W-1:0] wide_q
);
    logic hi_wr;
    assign hi_wr = op.is_wr && (op.kind == ACC_WIDE_HI);

    for (genvar k = 0; k < N_WIDE; k++) begin : g_reg
        logic hit;
        assign hit = hi_wr && (op.idx == byte_t'(k));
        if (k == CNT_IDX) begin : g_cnt
            always_ff @(posedge clk) begin
                if (rst)          wide_q[k] <= '0;
                else if (hit)     wide_q[k] <= {op.data, temp_q};
                else if (cnt_run) wide_q[k] <= wide_q[k] + word_t'(1);
            end
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst)      wide_q[k] <= '0;
                else if (hit) wide_q[k] <= {op.data, temp_q};
            end
        end
    end
endmodule

// File: rtl/tbb_narrow_bank.sv
module tbb_narrow_bank
    import tbb_pkg::*;
#(
    parameter int N_NARROW = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_op_t                       op,
    output logic [N_NARROW-1:0][BYTE_W-1:0] narrow_q
);
    for (genvar k = 0; k < N_NARROW; k++) begin : g_nreg
        always_ff @(posedge clk) begin
            if (rst)
                narrow_q[k] <= '0;
            else if (op.is_wr && op.kind == ACC_NARROW && op.idx == byte_t'(k))
                narrow_q[k] <= op.data;
        end
    end
endmodule

// File: rtl/tmr_byte_bridge.sv
module tmr_byte_bridge
    import tbb_pkg::*;
#(
    parameter int N_WIDE   = 4,
    parameter int N_NARROW = 2,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_run,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int IW  = (N_WIDE > 1)   ? $clog2(N_WIDE)   : 1;
    localparam int NIW = (N_NARROW > 1) ? $clog2(N_NARROW) : 1;

    bus_op_t                         op;
    byte_t                           temp_q;
    byte_t                           sel_hi;
    logic [N_WIDE-1:0][WORD_W-1:0]   wide_q;
    logic [N_NARROW-1:0][BYTE_W-1:0] narrow_q;
    word_t                           sel_word;

    tbb_decode #(.N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .op       (op)
    );

    assign sel_word = wide_q[op.idx[IW-1:0]];
    assign sel_hi   = sel_word[WORD_W-1:BYTE_W];

    tbb_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .sel_hi(sel_hi),
        .temp_q(temp_q)
    );

    tbb_wide_bank #(.N_WIDE(N_WIDE), .CNT_IDX(0)) u_wide (
        .clk    (clk),
        .rst    (rst),
        .cnt_run(cnt_run),
        .op     (op),
        .temp_q (temp_q),
        .wide_q (wide_q)
    );

    tbb_narrow_bank #(.N_NARROW(N_NARROW)) u_narrow (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .narrow_q(narrow_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.is_rd) begin
            unique case (op.kind)
                ACC_WIDE_LO: bus_rdata = sel_word[BYTE_W-1:0];
                ACC_WIDE_HI: bus_rdata = temp_q;
                ACC_NARROW:  bus_rdata = narrow_q[op.idx[NIW-1:0]];
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tbb_check.sv
module tbb_check
#(
    parameter int N_WIDE   = 4,
    parameter int N_NARROW = 2,
    parameter int ADDR_W   = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cnt_run,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [7:0]                  bus_wdata,
    input logic [7:0]                  bus_rdata,
    input logic [7:0]                  temp_q,
    input logic [N_WIDE-1:0][15:0]     wide_q
);
    localparam int IW = (N_WIDE > 1) ? $clog2(N_WIDE) : 1;
    localparam logic [ADDR_W-1:0] WIDE_END   = ADDR_W'(2 * N_WIDE);
    localparam logic [ADDR_W-1:0] NARROW_END = ADDR_W'(2 * N_WIDE + N_NARROW);

    logic in_wide, in_narrow;
    logic [IW-1:0] widx;
    logic [15:0]   cur_word;
    assign in_wide   = bus_addr < WIDE_END;
    assign in_narrow = !in_wide && (bus_addr < NARROW_END);
    assign widx      = bus_addr[IW:1];
    assign cur_word  = wide_q[widx];

    // Pending-check registers for the next-cycle properties.
    logic          hw_pend, lr_pend;
    logic [IW-1:0] hw_idx;
    logic [15:0]   hw_exp;
    logic [7:0]    lr_hi;
    always_ff @(posedge clk) begin
        hw_pend <= !rst && bus_wr && in_wide && bus_addr[0];
        hw_idx  <= widx;
        hw_exp  <= {bus_wdata, temp_q};
        lr_pend <= !rst && bus_rd && !bus_wr && in_wide && !bus_addr[0];
        lr_hi   <= cur_word[15:8];
    end

    assert_stage_cleared_R1: assert property (@(posedge clk)
        $past(rst) |-> temp_q == 8'h00);

    assert_low_write_stages_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_wide && !bus_addr[0]) |=> temp_q == $past(bus_wdata));

    assert_high_write_commits_R3: assert property (@(posedge clk) disable iff (rst)
        hw_pend |-> wide_q[hw_idx] == hw_exp);

    assert_low_read_snapshots_R4: assert property (@(posedge clk) disable iff (rst)
        lr_pend |-> temp_q == lr_hi);

    assert_high_read_from_stage_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && in_wide && bus_addr[0]) |-> bus_rdata == temp_q);

    assert_count_wraps_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_run && wide_q[0] == 16'hFFFF && !(bus_wr && bus_addr == ADDR_W'(1)))
        |=> wide_q[0] == 16'h0000);

    assert_narrow_keeps_stage_R8: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && in_narrow) |=> $stable(temp_q));

    assert_idle_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || bus_wr || bus_addr >= NARROW_END) |-> bus_rdata == 8'h00);
endmodule

bind tmr_byte_bridge tbb_check #(
    .N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_run  (cnt_run),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .temp_q   (temp_q),
    .wide_q   (wide_q)
);

// File: tb/tb_tmr_byte_bridge.sv
module tb_tmr_byte_bridge;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_run = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    tmr_byte_bridge #(.N_WIDE(4), .N_NARROW(2), .ADDR_W(4)) dut (
        .clk(clk), .rst(rst), .cnt_run(cnt_run), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic       chk;
        logic [7:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 4'd2,  8'h34, 1'b0, 8'h00, "R2 "}, // low write reg1
        '{1'b0, 1'b1, 4'd3,  8'h00, 1'b1, 8'h34, "R2 "}, // stage holds 34, reg1 untouched
        '{1'b0, 1'b1, 4'd2,  8'h00, 1'b1, 8'h00, "R2 "}, // reg1 low still 0
        '{1'b1, 1'b0, 4'd2,  8'h34, 1'b0, 8'h00, "R3 "},
        '{1'b1, 1'b0, 4'd3,  8'h12, 1'b0, 8'h00, "R3 "}, // reg1 = 1234
        '{1'b0, 1'b1, 4'd2,  8'h00, 1'b1, 8'h34, "R4 "},
        '{1'b0, 1'b1, 4'd3,  8'h00, 1'b1, 8'h12, "R3 "},
        '{1'b1, 1'b0, 4'd8,  8'h5A, 1'b0, 8'h00, "R8 "},
        '{1'b0, 1'b1, 4'd8,  8'h00, 1'b1, 8'h5A, "R8 "},
        '{1'b1, 1'b0, 4'd4,  8'h77, 1'b0, 8'h00, "R8 "}, // low write reg2
        '{1'b1, 1'b0, 4'd9,  8'hC3, 1'b0, 8'h00, "R8 "}, // narrow write between halves
        '{1'b1, 1'b0, 4'd5,  8'h66, 1'b0, 8'h00, "R8 "}, // reg2 = 6677
        '{1'b0, 1'b1, 4'd9,  8'h00, 1'b1, 8'hC3, "R8 "},
        '{1'b0, 1'b1, 4'd4,  8'h00, 1'b1, 8'h77, "R8 "}, // stage <= 66
        '{1'b1, 1'b0, 4'd15, 8'hFF, 1'b0, 8'h00, "R11"}, // unmapped write
        '{1'b0, 1'b1, 4'd5,  8'h00, 1'b1, 8'h66, "R11"}  // stage unchanged by it
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bus_rdata=%02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge; sample the read byte 1 ns later.
    task automatic xfer(input logic wr, input logic rd, input logic [3:0] addr,
                        input logic [7:0] data, output logic [7:0] rd_byte);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = data;
        #1 rd_byte = bus_rdata;
    endtask

    task automatic wr8(input logic [3:0] addr, input logic [7:0] data);
        logic [7:0] unused;
        xfer(1'b1, 1'b0, addr, data, unused);
    endtask

    task automatic rd8(input logic [3:0] addr, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        xfer(1'b0, 1'b1, addr, 8'h00, got);
        check(got, exp, tag);
    endtask

    task automatic idle();
        logic [7:0] got;
        xfer(1'b0, 1'b0, 4'd0, 8'h00, got);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and R11 idle output
        idle();
        check(bus_rdata, 8'h00, "R11 idle");
        rd8(4'd0, 8'h00, "R1 counter low");
        rd8(4'd1, 8'h00, "R1 counter high");
        rd8(4'd6, 8'h00, "R1 reg3 low");
        rd8(4'd9, 8'h00, "R1 narrow1");
        rd8(4'd14, 8'h00, "R11 unmapped read");

        // Vector table, counter stopped
        for (int i = 0; i < NV; i++) begin
            xfer(TBL[i].wr, TBL[i].rd, TBL[i].addr, TBL[i].wdata, got);
            if (TBL[i].chk) check(got, TBL[i].exp, $sformatf("%s row %0d", TBL[i].tag, i));
        end

        // R6 wrap from FFFF
        wr8(4'd0, 8'hFF);
        wr8(4'd1, 8'hFF);
        rd8(4'd0, 8'hFF, "R6 preset low");
        @(negedge clk); cnt_run = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk); cnt_run = 1'b0;
        rd8(4'd0, 8'h00, "R6 wrapped low");
        rd8(4'd1, 8'h00, "R6 wrapped high");

        // R7 write while running, R4/R5 snapshot across the carry
        @(negedge clk); cnt_run = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        wr8(4'd0, 8'hFF);
        wr8(4'd1, 8'h00);                         // counter = 00FF exactly
        rd8(4'd0, 8'hFF, "R7 written value exact");
        rd8(4'd1, 8'h00, "R5 snapshot high across carry");
        rd8(4'd0, 8'h01, "R6 counted on");        // 00FF+2 = 0101
        rd8(4'd1, 8'h01, "R4 high captured");
        @(negedge clk); cnt_run = 1'b0; bus_rd = 1'b0;

        // R9 interleaved writes corrupt via shared stage
        wr8(4'd2, 8'hAA);
        wr8(4'd4, 8'h55);
        wr8(4'd3, 8'h11);                         // reg1 = 1155
        rd8(4'd2, 8'h55, "R9 corrupted low");
        rd8(4'd3, 8'h11, "R9 high");
        rd8(4'd4, 8'h77, "R9 reg2 low kept");     // stage <= 66
        wr8(4'd7, 8'h22);                         // reg3 = 2266
        rd8(4'd6, 8'h66, "R9 read-then-write corrupts low");
        rd8(4'd7, 8'h22, "R9 reg3 high");

        // R10 simultaneous strobes
        xfer(1'b1, 1'b1, 4'd2, 8'h99, got);
        check(got, 8'h00, "R10 no read data");
        rd8(4'd3, 8'h99, "R10 write performed");
        rd8(4'd2, 8'h55, "R10 target unchanged");

        // R1 reset in the middle of a two-byte write
        wr8(4'd2, 8'hAB);
        @(negedge clk); bus_wr = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd8(4'd3, 8'h00, "R1 stage cleared");
        rd8(4'd2, 8'h00, "R1 reg1 cleared");
        rd8(4'd8, 8'h00, "R1 narrow cleared");
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule